// File: doc/BRIEF.md
# Overlay Window Read Address Generator

This block walks the frame buffer of one overlay window and produces the word addresses a display fetch engine must read. A window may show only a sub-rectangle of a wider buffer. For that reason the generator reads a fixed number of bytes for each visible line. It then jumps over the bytes of the line that are not visible and continues at the start of the next line. It stops once the configured end address is reached.

Each read is a burst request with a word count. The request stays on the port until the fabric grants it. The largest burst depends on the pixel depth. A line whose remaining width is smaller than a full burst ends with a shorter burst. A one-cycle frame-start pulse restarts the walk at the start address. A done flag tells the fetch engine that the frame has been fully requested.

Software supplies the following values:
- the start address, already offset to the top-left source pixel;
- the visible line width in bytes;
- the per-line skip in bytes, which is (buffer width − visible width) × bytes per pixel;
- the end address, which is start + buffer width × visible height × bytes per pixel.

All addresses and byte counts are multiples of 4. One word is 4 bytes.

Top module: `fb_win_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `req_o` is 0 and `done_o` is 1 until a frame starts.
- R2: When `enable_i` is 0, `req_o` is 0 and `done_o` is 1. A frame-start pulse seen while disabled has no effect: no request follows it and `done_o` stays 1.
- R3: A frame-start pulse sampled at a clock edge on an enabled window makes `req_o` 1 in the next cycle, with `req_addr_o` equal to the start address and `done_o` 0.
- R4: The largest burst, in words, depends on `depth_i` (bits per pixel): 1 gives 4 words; 2, 4 and 8 give 8 words; 16, 24 and 32 give 16 words.
- R5: Any other `depth_i` value uses 16-word bursts.
- R6: Within a line, each granted burst moves the next request address on by 4 × `req_len_o` bytes.
- R7: A line is split into bursts of the maximum length, followed by one final burst that carries the remaining words of the line (page width / 4 in total).
- R8: After the last burst of a line is granted, the next address is the end of that line plus `skip_i` bytes. The next line again starts with a full page width.
- R9: While `req_o` is 1 and `gnt_i` is 0, the request, its address and its length stay unchanged in the next cycle.
- R10: When the granted burst brings the next address to, or past, `end_addr_i`, the following cycle shows `req_o` 0 and `done_o` 1. `done_o` then stays 1 until the next frame start.
- R11: If a frame starts while the start address is not below the end address, or while the page width is 0, no request is issued and `done_o` is 1 in the next cycle.
- R12: A frame-start pulse in the middle of a frame discards the walk in progress, including a grant in the same cycle. The next request is at the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Window enable |
| frame_start_i | input | 1 | One-cycle pulse that restarts the walk |
| start_addr_i | input | AW | Byte address of the first visible pixel |
| end_addr_i | input | AW | Byte address at which the frame ends |
| page_width_i | input | LW | Visible bytes per line |
| skip_i | input | LW | Bytes skipped after each line |
| depth_i | input | DEPTH_W | Bits per pixel |
| gnt_i | input | 1 | Grant for the pending request |
| req_o | output | 1 | Read request valid |
| req_addr_o | output | AW | Byte address of the burst |
| req_len_o | output | 5 | Burst length in words |
| done_o | output | 1 | Frame fully requested, or window disabled |

## Verification
Several properties are checked on every cycle:
- a disabled window is idle and reports done;
- a stalled request holds its address and length;
- a burst length is never 0 and never above 16 words;
- a request and done are never high together;
- done persists until the next frame start;
- a granted burst never moves the address backwards.

Other behaviours can only be shown by the bench's scenarios, because each needs an address list worked out from a frame configuration:
- the exact burst split per depth;
- the short tail burst of a line;
- the skip jump between lines;
- where the frame ends;
- the restart in the middle of a frame;
- the empty-frame case.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  localparam int WORD_BYTES  = 4;
  localparam int BURST_LEN_W = 5;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/fbag_burst_sel.sv
module fbag_burst_sel #(
  parameter int DEPTH_W     = 6,
  parameter int LEN_W       = 5,
  parameter int SHORT_WORDS = 4,
  parameter int MID_WORDS   = 8,
  parameter int LONG_WORDS  = 16
) (
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [LEN_W-1:0]   max_words_o
);
  always_comb begin
    unique case (depth_i)
      DEPTH_W'(1):                            max_words_o = LEN_W'(SHORT_WORDS);
      DEPTH_W'(2), DEPTH_W'(4), DEPTH_W'(8): max_words_o = LEN_W'(MID_WORDS);
      // 16/24/32 and any unknown depth
      default:                                max_words_o = LEN_W'(LONG_WORDS);
    endcase
  end
endmodule

// File: rtl/fbag_line_step.sv
module fbag_line_step #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [LW-1:0]    page_words_i,
  input  logic [LW-1:0]    skip_i,
  input  logic [LEN_W-1:0] max_words_i,
  output logic [AW-1:0]    addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic [AW-1:0]    next_addr_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] max_ext, len_w;
  logic          line_end;
  logic [AW-1:0] step_bytes;

  assign max_ext    = LW'(max_words_i);
  assign len_w      = (rem_q < max_ext) ? rem_q : max_ext;
  assign line_end   = (rem_q == len_w);
  assign step_bytes = AW'(len_w) << 2;

  assign addr_o      = addr_q;
  assign len_o       = LEN_W'(len_w);
  assign next_addr_o = addr_q + step_bytes + (line_end ? AW'(skip_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= start_addr_i;
      rem_q  <= page_words_i;
    end else if (adv_i) begin
      addr_q <= next_addr_o;
      rem_q  <= line_end ? page_words_i : rem_q - len_w;
    end
  end
endmodule

// File: rtl/fbag_ctrl.sv
module fbag_ctrl
  import fbag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic frame_start_i,
  input  logic empty_i,
  input  logic last_i,
  input  logic gnt_i,
  output logic load_o,
  output logic adv_o,
  output logic active_o,
  output logic done_o
);
  run_state_e state_q;
  logic       done_q;

  assign load_o   = enable_i & frame_start_i;
  assign active_o = (state_q == ST_RUN) & enable_i;
  assign adv_o    = active_o & gnt_i & ~frame_start_i;
  assign done_o   = done_q | ~enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else if (frame_start_i) begin
      state_q <= empty_i ? ST_IDLE : ST_RUN;
      done_q  <= empty_i;
    end else if (adv_o && last_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/fb_win_addr_gen.sv
module fb_win_addr_gen
  import fbag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int DEPTH_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic                   frame_start_i,
  input  logic [AW-1:0]          start_addr_i,
  input  logic [AW-1:0]          end_addr_i,
  input  logic [LW-1:0]          page_width_i,
  input  logic [LW-1:0]          skip_i,
  input  logic [DEPTH_W-1:0]     depth_i,
  input  logic                   gnt_i,
  output logic                   req_o,
  output logic [AW-1:0]          req_addr_o,
  output logic [BURST_LEN_W-1:0] req_len_o,
  output logic                   done_o
);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);

  logic [BURST_LEN_W-1:0] max_words;
  logic [LW-1:0]          page_words;
  logic [AW-1:0]          next_addr;
  logic                   load, adv, empty, last;

  assign page_words = page_width_i >> WORD_SHIFT;
  assign empty      = (start_addr_i >= end_addr_i) || (page_words == '0);
  assign last       = (next_addr >= end_addr_i);

  fbag_burst_sel #(.DEPTH_W(DEPTH_W), .LEN_W(BURST_LEN_W)) u_burst_sel (
    .depth_i     (depth_i),
    .max_words_o (max_words)
  );

  fbag_line_step #(.AW(AW), .LW(LW), .LEN_W(BURST_LEN_W)) u_line_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .adv_i        (adv),
    .start_addr_i (start_addr_i),
    .page_words_i (page_words),
    .skip_i       (skip_i),
    .max_words_i  (max_words),
    .addr_o       (req_addr_o),
    .len_o        (req_len_o),
    .next_addr_o  (next_addr)
  );

  fbag_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .frame_start_i (frame_start_i),
    .empty_i       (empty),
    .last_i        (last),
    .gnt_i         (gnt_i),
    .load_o        (load),
    .adv_o         (adv),
    .active_o      (req_o),
    .done_o        (done_o)
  );
endmodule

// File: rtl/fb_win_addr_gen_chk.sv
module fb_win_addr_gen_chk
  import fbag_pkg::*;
#(
  parameter int AW = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   enable_i,
  input logic                   frame_start_i,
  input logic                   gnt_i,
  input logic                   req_o,
  input logic [AW-1:0]          req_addr_o,
  input logic [BURST_LEN_W-1:0] req_len_o,
  input logic                   done_o
);
  a_r2_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!req_o && done_o));

  a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && enable_i && !frame_start_i) |=>
      (!enable_i || (req_o && $stable(req_addr_o) && $stable(req_len_o))));

  a_r4_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_len_o != '0 && req_len_o <= BURST_LEN_W'(16)));

  a_r10_req_excl_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !done_o);

  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !frame_start_i) |=> done_o);

  a_r6_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && !frame_start_i) |=>
      (!req_o || ({1'b0, req_addr_o} >=
        {1'b0, $past(req_addr_o)} + {{(AW-BURST_LEN_W-1){1'b0}}, $past(req_len_o), 2'b00})));
endmodule

bind fb_win_addr_gen fb_win_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .frame_start_i (frame_start_i),
  .gnt_i         (gnt_i),
  .req_o         (req_o),
  .req_addr_o    (req_addr_o),
  .req_len_o     (req_len_o),
  .done_o        (done_o)
);

// File: tb/fb_win_addr_gen_test.sv
`timescale 1ns/1ps
module fb_win_addr_gen_test;
  typedef struct packed {
    logic [31:0] addr;
    logic [4:0]  len;
  } burst_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [31:0] end_addr_i = '0;
  logic [15:0] page_width_i = '0;
  logic [15:0] skip_i = '0;
  logic [5:0]  depth_i = '0;
  logic        gnt_i = 1'b0;
  logic        req_o;
  logic [31:0] req_addr_o;
  logic [4:0]  req_len_o;
  logic        done_o;

  int     checks = 0;
  int     errors = 0;
  int     grants = 0;
  int     gnt_mode = 0;
  bit     finished = 1'b0;
  bit     stall_q = 1'b0;
  logic [31:0] stall_addr;
  logic [4:0]  stall_len;
  burst_t sb[$];

  always #2 clk_i = ~clk_i;

  fb_win_addr_gen uut (
    .clk_i, .rst_ni, .enable_i, .frame_start_i, .start_addr_i, .end_addr_i,
    .page_width_i, .skip_i, .depth_i, .gnt_i, .req_o, .req_addr_o,
    .req_len_o, .done_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max_burst(input int d);
    case (d)
      1:       return 4;
      2, 4, 8: return 8;
      default: return 16;
    endcase
  endfunction

  // grant pattern: mode 0 always, mode 1 every third cycle
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i); #1;
      cyc++;
      gnt_i = (gnt_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    end
  end

  // monitor: scoreboard pop and stall hold
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (stall_q) begin
        chk(req_o && req_addr_o == stall_addr && req_len_o == stall_len,
            "R9 stalled request held", req_addr_o, stall_addr);
      end
      stall_q = 1'b0;
      if (!frame_start_i && enable_i) begin
        if (req_o && gnt_i) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R10 request after expected end", req_addr_o, 0);
          end else begin
            burst_t e;
            e = sb.pop_front();
            chk(req_addr_o == e.addr, "R6 R8 burst address", req_addr_o, e.addr);
            chk(req_len_o == e.len, "R4 R7 burst length", req_len_o, e.len);
          end
          grants++;
        end else if (req_o) begin
          stall_q = 1'b1;
          stall_addr = req_addr_o;
          stall_len = req_len_o;
        end
      end
    end
  end

  task automatic prep(input logic [31:0] s, input logic [31:0] e, input logic [15:0] pw,
                      input logic [15:0] sk, input logic [5:0] d, output int n);
    int mb = max_burst(int'(d));
    int rem = int'(pw) / 4;
    logic [31:0] a = s;
    sb.delete();
    start_addr_i = s; end_addr_i = e; page_width_i = pw; skip_i = sk; depth_i = d;
    n = 0;
    if (s < e && rem > 0) begin
      forever begin
        int l = (rem < mb) ? rem : mb;
        burst_t b;
        b.addr = a; b.len = 5'(l);
        sb.push_back(b);
        n++;
        a = a + 32'(4 * l);
        rem = rem - l;
        if (rem == 0) begin
          a = a + 32'(sk);
          rem = int'(pw) / 4;
        end
        if (a >= e) break;
      end
    end
    grants = 0;
  endtask

  task automatic pulse;
    frame_start_i = 1'b1;
    @(posedge clk_i); #1;
    frame_start_i = 1'b0;
  endtask

  task automatic finish_frame(input int n, input string tag);
    int w = 0;
    while (!done_o && w < 5000) begin
      @(negedge clk_i);
      w++;
    end
    chk(done_o, "R10 done reached", done_o, 1);
    chk(grants == n && sb.size() == 0, {"R10 burst count ", tag}, grants, n);
    repeat (4) @(negedge clk_i);
    chk(done_o && !req_o, "R10 done held, no request", {done_o, req_o}, 2);
  endtask

  task automatic run_frame(input logic [31:0] s, input logic [31:0] e, input logic [15:0] pw,
                           input logic [15:0] sk, input logic [5:0] d, input string tag);
    int n;
    @(posedge clk_i); #1;
    prep(s, e, pw, sk, d, n);
    pulse();
    @(negedge clk_i);
    chk(req_o && req_addr_o == s && !done_o, {"R3 first request ", tag}, req_addr_o, s);
    finish_frame(n, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk(!req_o && done_o, "R1 in reset", {req_o, done_o}, 1);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!req_o && done_o, "R1 after reset", {req_o, done_o}, 1);

    // R2: disabled window ignores frame start
    @(posedge clk_i); #1;
    prep(32'h100, 32'h200, 16'd64, 16'd0, 6'd32, n);
    sb.delete();
    pulse();
    repeat (4) begin
      @(negedge clk_i);
      chk(!req_o && done_o, "R2 disabled idle", {req_o, done_o}, 1);
    end
    @(posedge clk_i); #1;
    enable_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!req_o && done_o && grants == 0, "R2 no effect after enable", {req_o, done_o}, 1);

    // R4 R6: 32 bpp, full 16-word lines, no skip, 3 lines
    run_frame(32'h1000, 32'h1000 + 32'd192, 16'd64, 16'd0, 6'd32, "32bpp");
    // R7 R8: 16 bpp, 20 words per line, skip 32, 3 lines, slow grant
    gnt_mode = 1;
    run_frame(32'h2004, 32'h2004 + 32'd336, 16'd80, 16'd32, 6'd16, "16bpp skip");
    gnt_mode = 0;
    // R4 R7: 8 bpp, 9 words per line
    run_frame(32'h3000, 32'h3000 + 32'd96, 16'd36, 16'd12, 6'd8, "8bpp");
    // R4: 1 bpp, 4-word bursts
    run_frame(32'h4000, 32'h4000 + 32'd64, 16'd24, 16'd8, 6'd1, "1bpp");
    run_frame(32'h5000, 32'h5000 + 32'd64, 16'd32, 16'd0, 6'd2, "2bpp");
    gnt_mode = 1;
    run_frame(32'h5800, 32'h5800 + 32'd96, 16'd32, 16'd16, 6'd4, "4bpp");
    gnt_mode = 0;
    run_frame(32'h6000, 32'h6000 + 32'd160, 16'd80, 16'd0, 6'd24, "24bpp");
    // R5: unknown depth uses 16-word bursts
    run_frame(32'h7000, 32'h7000 + 32'd80, 16'd80, 16'd0, 6'd5, "R5 depth 5");

    // R11: empty frames
    @(posedge clk_i); #1;
    prep(32'h8000, 32'h8000, 16'd64, 16'd0, 6'd32, n);
    pulse();
    @(negedge clk_i);
    chk(!req_o && done_o, "R11 start equals end", {req_o, done_o}, 1);
    @(posedge clk_i); #1;
    prep(32'h8000, 32'h9000, 16'd0, 16'd0, 6'd32, n);
    pulse();
    repeat (3) @(negedge clk_i);
    chk(!req_o && done_o && grants == 0, "R11 zero page width", grants, 0);

    // R12: restart mid-frame
    @(posedge clk_i); #1;
    prep(32'hA000, 32'hA000 + 32'd4096, 16'd64, 16'd0, 6'd8, n);
    pulse();
    while (grants < 3) @(negedge clk_i);
    @(posedge clk_i); #1;
    prep(32'hC000, 32'hC000 + 32'd128, 16'd32, 16'd32, 6'd16, n);
    pulse();
    @(negedge clk_i);
    chk(req_o && req_addr_o == 32'hC000, "R12 restart address", req_addr_o, 32'hC000);
    finish_frame(n, "R12 restart");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule